// File: doc/BRIEF.md
# Programmable CRC Engine with Transposition

A register-mapped CRC accumulator. Software picks a generator polynomial and a result width, loads a starting value, then writes data words through a 32-bit register bus with byte enables. Every write folds the enabled bytes of the word into the running CRC within a single clock edge. Reading the data register returns the current checksum.

The control register sets two separate four-way reorderings, one for data on the way in and one for the result on the way out. It can also invert the result on read. With these options the same engine computes both MSB-first CRCs and reflected ones, such as the common Ethernet and zip CRC-32, without any software bit shuffling.

The bus is a single-cycle interface with a word index on `addr_i`. Read data is combinational while a read is requested.

Top module: `crc_xpose_engine`

## Requirements
- R1: Word index 0 (byte offset 0x0) is the data/result register, 1 (0x4) is the polynomial and 2 (0x8) is control. Index 3 reads zero and ignores writes. `rdata_o` is zero in any cycle without a read request.
- R2: After reset, control reads 0x00000000, the polynomial reads 0x00001021 and the CRC state is all ones, so a data read in the reset (16-bit) mode returns 0x0000FFFF.
- R3: Polynomial and control writes update only the byte lanes whose enable is set (lane k = bits 8k+7..8k). Control keeps only bits 31:28 and 26:24, and every other control bit reads zero.
- R4: Control bit 24 selects the width: 0 is 16-bit and 1 is 32-bit. In 16-bit mode only polynomial bits 15:0 and state bits 15:0 take part, and the result's upper half is zero before read transposition.
- R5: With seed mode off, a data write feeds each enabled byte into the CRC MSB-first: state ^= byte placed at the top of the width, then eight shift-left steps, XORing in the polynomial when the bit shifted out is 1. Lanes are taken from lane 0 upward, and all of it finishes in one cycle. A write with no enabled lane leaves the state unchanged.
- R6: With control bit 25 set, a data write copies each enabled (transposed) byte lane straight into the matching lane of the state, and no CRC step is taken.
- R7: Control bits 31:30 transpose written data: 0 none, 1 bit order reversed inside each byte, 2 all 32 bits reversed, 3 byte order reversed. In modes 2 and 3 the lane enables are reversed with the bytes. This applies to both CRC and seed writes.
- R8: Control bits 29:28 transpose the data-register read value, using the same four encodings as R7.
- R9: With control bit 26 set, a data read returns the result XORed with all ones of the selected width (0xFFFF or 0xFFFFFFFF). The complement is applied before read transposition.
- R10: Reads, complement and read transposition never change the stored CRC state, the polynomial or the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register word index |
| be_i | input | 4 | Byte-lane enables for writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero when not reading |

## Verification
The bench sweeps every combination of width, write transposition, read transposition and complement. Each combination runs a partial-enable stream against a bit-serial model, so a swapped transposition code, lane enables that do not follow reversed bytes, or a complement applied after the reorder would give wrong checksums. Known check values for CRC-16/CCITT, MSB-first CRC-32 and reflected CRC-32 catch a wrong shift direction or feedback tap. The bench loads a 16-bit mode polynomial with garbage in its upper half, so a design that lets the upper half leak into the narrow CRC fails. Partial seed loads, empty-enable writes, reads between complement toggles and writes to the unused index would all show corruption of the stored state.

// File: rtl/crc_xpose_pkg.sv
`timescale 1ns/1ps
package crc_xpose_pkg;
  localparam int unsigned LANES    = 4;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned WORD_W   = LANES * BYTE_W;
  localparam int unsigned NARROW_W = WORD_W / 2;

  localparam int unsigned CTRL_WIDE = 24;
  localparam int unsigned CTRL_SEED = 25;
  localparam int unsigned CTRL_INV  = 26;
  localparam int unsigned CTRL_RDX  = 28;
  localparam int unsigned CTRL_WRX  = 30;
  localparam logic [WORD_W-1:0] CTRL_MASK = 32'hF700_0000;

  typedef enum logic [1:0] {
    XP_NONE  = 2'd0,
    XP_BITS  = 2'd1,
    XP_ALL   = 2'd2,
    XP_BYTES = 2'd3
  } xpose_e;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_POLY = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // one byte through the polynomial, MSB first; narrow mode keeps the upper half
  function automatic logic [WORD_W-1:0] crc_byte_step(
    input logic [WORD_W-1:0] st,
    input logic [BYTE_W-1:0] b,
    input logic [WORD_W-1:0] poly,
    input logic              wide
  );
    logic [WORD_W-1:0]   s;
    logic [NARROW_W-1:0] t;
    s = st;
    t = st[NARROW_W-1:0];
    if (wide) begin
      s = s ^ {b, {(WORD_W-BYTE_W){1'b0}}};
      for (int i = 0; i < BYTE_W; i++)
        s = s[WORD_W-1] ? ((s << 1) ^ poly) : (s << 1);
    end else begin
      t = t ^ {b, {(NARROW_W-BYTE_W){1'b0}}};
      for (int i = 0; i < BYTE_W; i++)
        t = t[NARROW_W-1] ? ((t << 1) ^ poly[NARROW_W-1:0]) : (t << 1);
      s = {st[WORD_W-1:NARROW_W], t};
    end
    return s;
  endfunction

  function automatic logic [WORD_W-1:0] merge_lanes(
    input logic [WORD_W-1:0] old_v,
    input logic [WORD_W-1:0] new_v,
    input logic [LANES-1:0]  en
  );
    logic [WORD_W-1:0] r;
    r = old_v;
    for (int k = 0; k < LANES; k++)
      if (en[k]) r[k*BYTE_W +: BYTE_W] = new_v[k*BYTE_W +: BYTE_W];
    return r;
  endfunction

  function automatic logic [LANES-1:0] rev_lanes(input logic [LANES-1:0] en);
    logic [LANES-1:0] r;
    for (int k = 0; k < LANES; k++) r[k] = en[LANES-1-k];
    return r;
  endfunction
endpackage

// File: rtl/crc_xpose_swizzle.sv
`timescale 1ns/1ps
module crc_xpose_swizzle
  import crc_xpose_pkg::*;
(
  input  logic [WORD_W-1:0] data_i,
  input  xpose_e            mode_i,
  output logic [WORD_W-1:0] data_o
);
  logic [WORD_W-1:0] bit_rev;
  logic [WORD_W-1:0] byte_rev;
  logic [WORD_W-1:0] all_rev;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    for (genvar j = 0; j < BYTE_W; j++) begin : g_bit
      assign bit_rev[k*BYTE_W+j]  = data_i[k*BYTE_W+(BYTE_W-1-j)];
      assign byte_rev[k*BYTE_W+j] = data_i[(LANES-1-k)*BYTE_W+j];
      assign all_rev[k*BYTE_W+j]  = data_i[WORD_W-1-(k*BYTE_W+j)];
    end
  end

  always_comb begin
    unique case (mode_i)
      XP_BITS:  data_o = bit_rev;
      XP_ALL:   data_o = all_rev;
      XP_BYTES: data_o = byte_rev;
      default:  data_o = data_i;
    endcase
  end
endmodule

// File: rtl/crc_xpose_core.sv
`timescale 1ns/1ps
module crc_xpose_core
  import crc_xpose_pkg::*;
(
  input  logic [WORD_W-1:0] state_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [LANES-1:0]  en_i,
  input  logic [WORD_W-1:0] poly_i,
  input  logic              wide_i,
  output logic [WORD_W-1:0] state_o
);
  logic [WORD_W-1:0] chain [LANES+1];

  assign chain[0] = state_i;

  // lane 0 first; disabled lanes pass the state through
  for (genvar k = 0; k < LANES; k++) begin : g_step
    assign chain[k+1] = en_i[k]
      ? crc_byte_step(chain[k], data_i[k*BYTE_W +: BYTE_W], poly_i, wide_i)
      : chain[k];
  end

  assign state_o = chain[LANES];
endmodule

// File: rtl/crc_xpose_engine.sv
`timescale 1ns/1ps
module crc_xpose_engine
  import crc_xpose_pkg::*;
#(
  parameter logic [WORD_W-1:0] POLY_RST = 32'h0000_1021
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam logic [WORD_W-1:0] NARROW_ONES = {{NARROW_W{1'b0}}, {NARROW_W{1'b1}}};

  logic [WORD_W-1:0] ctrl_q, poly_q, state_q;
  logic [WORD_W-1:0] wdata_x, state_upd, state_seed, state_d;
  logic [WORD_W-1:0] res_raw, res_inv, res_x;
  logic [LANES-1:0]  be_x;
  reg_sel_e          sel;
  xpose_e            wr_mode, rd_mode;
  logic              wide, seed_mode, inv_rd;

  assign sel       = reg_sel_e'(addr_i);
  assign wide      = ctrl_q[CTRL_WIDE];
  assign seed_mode = ctrl_q[CTRL_SEED];
  assign inv_rd    = ctrl_q[CTRL_INV];
  assign wr_mode   = xpose_e'(ctrl_q[CTRL_WRX +: 2]);
  assign rd_mode   = xpose_e'(ctrl_q[CTRL_RDX +: 2]);

  // write path: reorder data, enables follow the bytes in modes 2 and 3
  crc_xpose_swizzle u_wr_swz (
    .data_i (wdata_i),
    .mode_i (wr_mode),
    .data_o (wdata_x)
  );

  assign be_x = wr_mode[1] ? rev_lanes(be_i) : be_i;

  crc_xpose_core u_core (
    .state_i (state_q),
    .data_i  (wdata_x),
    .en_i    (be_x),
    .poly_i  (poly_q),
    .wide_i  (wide),
    .state_o (state_upd)
  );

  assign state_seed = merge_lanes(state_q, wdata_x, be_x);
  assign state_d    = seed_mode ? state_seed : state_upd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      poly_q  <= POLY_RST;
      state_q <= '1;
    end else if (req_i && we_i) begin
      unique case (sel)
        SEL_DATA: state_q <= state_d;
        SEL_POLY: poly_q  <= merge_lanes(poly_q, wdata_i, be_i);
        SEL_CTRL: ctrl_q  <= merge_lanes(ctrl_q, wdata_i, be_i) & CTRL_MASK;
        default: ;
      endcase
    end
  end

  // read path: width mask, complement, then reorder
  assign res_raw = wide ? state_q : (state_q & NARROW_ONES);
  assign res_inv = inv_rd ? (res_raw ^ (wide ? {WORD_W{1'b1}} : NARROW_ONES)) : res_raw;

  crc_xpose_swizzle u_rd_swz (
    .data_i (res_inv),
    .mode_i (rd_mode),
    .data_o (res_x)
  );

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (sel)
        SEL_DATA: rdata_o = res_x;
        SEL_POLY: rdata_o = poly_q;
        SEL_CTRL: rdata_o = ctrl_q;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/crc_xpose_chk.sv
`timescale 1ns/1ps
module crc_xpose_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [1:0]  addr_i,
  input logic [3:0]  be_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic [31:0] state_q,
  input logic [31:0] ctrl_q,
  input logic [31:0] poly_q
);
  // R1
  rd_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |-> rdata_o == 32'h0);

  // R3
  ctrl_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 2'd2) |-> (rdata_o & 32'h08FF_FFFF) == 32'h0);

  // R4
  narrow_high_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 2'd0 && !ctrl_q[24] && ctrl_q[29:28] == 2'd0)
    |-> rdata_o[31:16] == 16'h0);

  // R5
  empty_be_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 2'd0 && be_i == 4'h0) |=> $stable(state_q));

  // R6
  seed_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 2'd0 && be_i == 4'hF && ctrl_q[25] && ctrl_q[31:30] == 2'd0)
    |=> state_q == $past(wdata_i));

  // R9
  inv_wide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 2'd0 && ctrl_q[24] && ctrl_q[26] && ctrl_q[29:28] == 2'd0)
    |-> rdata_o == ~state_q);

  // R10
  rd_keeps_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> ($stable(state_q) && $stable(ctrl_q) && $stable(poly_q)));
endmodule

bind crc_xpose_engine crc_xpose_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .be_i    (be_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .state_q (state_q),
  .ctrl_q  (ctrl_q),
  .poly_q  (poly_q)
);

// File: tb/test_crc_xpose_engine.sv
`timescale 1ns/1ps
module test_crc_xpose_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [3:0]  be = 4'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] m_state = 32'hFFFF_FFFF;
  logic [31:0] m_poly  = 32'h0000_1021;
  logic [31:0] m_ctrl  = 32'h0;

  crc_xpose_engine i_crc_xpose_engine (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .we_i (we),
    .addr_i (addr), .be_i (be), .wdata_i (wdata), .rdata_o (rdata)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] m_xp(input logic [31:0] d, input logic [1:0] mode);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      case (mode)
        2'd1: r[i] = d[(i/8)*8 + (7 - i%8)];
        2'd2: r[i] = d[31 - i];
        2'd3: r[i] = d[(3 - i/8)*8 + i%8];
        default: r[i] = d[i];
      endcase
    end
    return r;
  endfunction

  // bit-serial reference
  function automatic logic [31:0] m_step(input logic [31:0] s, input logic [7:0] b,
                                         input logic [31:0] p, input logic wide);
    logic fb;
    logic [15:0] lo;
    for (int i = 7; i >= 0; i--) begin
      if (wide) begin
        fb = s[31] ^ b[i];
        s = {s[30:0], 1'b0};
        if (fb) s = s ^ p;
      end else begin
        fb = s[15] ^ b[i];
        lo = {s[14:0], 1'b0};
        if (fb) lo = lo ^ p[15:0];
        s = {s[31:16], lo};
      end
    end
    return s;
  endfunction

  function automatic logic [31:0] m_rd(input logic [1:0] a);
    logic [31:0] r;
    case (a)
      2'd0: begin
        r = m_ctrl[24] ? m_state : {16'h0, m_state[15:0]};
        if (m_ctrl[26]) r = r ^ (m_ctrl[24] ? 32'hFFFF_FFFF : 32'h0000_FFFF);
        return m_xp(r, m_ctrl[29:28]);
      end
      2'd1: return m_poly;
      2'd2: return m_ctrl;
      default: return 32'h0;
    endcase
  endfunction

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] e);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; be = e;
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = 4'h0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1;
    v = rdata;
    req = 1'b0;
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] e);
    logic [31:0] xd;
    logic [3:0]  xe;
    case (a)
      2'd0: begin
        xd = m_xp(d, m_ctrl[31:30]);
        xe = m_ctrl[31] ? {e[0], e[1], e[2], e[3]} : e;
        for (int k = 0; k < 4; k++)
          if (xe[k]) begin
            if (m_ctrl[25]) m_state[k*8 +: 8] = xd[k*8 +: 8];
            else m_state = m_step(m_state, xd[k*8 +: 8], m_poly, m_ctrl[24]);
          end
      end
      2'd1: for (int k = 0; k < 4; k++) if (e[k]) m_poly[k*8 +: 8] = d[k*8 +: 8];
      2'd2: begin
        for (int k = 0; k < 4; k++) if (e[k]) m_ctrl[k*8 +: 8] = d[k*8 +: 8];
        m_ctrl = m_ctrl & 32'hF700_0000;
      end
      default: ;
    endcase
    bus_wr(a, d, e);
  endtask

  task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic check_rd(input logic [1:0] a, input string tag);
    logic [31:0] v;
    bus_rd(a, v);
    check_val(tag, v, m_rd(a));
  endtask

  task automatic feed_ascii(input string s);
    for (int i = 0; i < s.len(); i++) do_wr(2'd0, {24'h0, s[i]}, 4'h1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset values
    bus_rd(2'd0, v); check_val("R2 data", v, 32'h0000_FFFF);
    bus_rd(2'd1, v); check_val("R2 poly", v, 32'h0000_1021);
    bus_rd(2'd2, v); check_val("R2 ctrl", v, 32'h0);
    #1; check_val("R1 idle rdata", rdata, 32'h0);

    // R5 CRC-16/CCITT check value
    feed_ascii("123456789");
    bus_rd(2'd0, v); check_val("R5 crc16 ccitt", v, 32'h0000_29B1);
    check_val("R5 crc16 model", v, m_rd(2'd0));

    // R5 empty enables
    do_wr(2'd0, 32'hDEAD_BEEF, 4'h0);
    check_rd(2'd0, "R5 empty be");

    // R3 lane writes and reserved control bits
    do_wr(2'd1, 32'h1122_3344, 4'h4);
    bus_rd(2'd1, v); check_val("R3 poly lane", v, 32'h0022_1021);
    do_wr(2'd2, 32'hFFFF_FFFF, 4'hF);
    bus_rd(2'd2, v); check_val("R3 ctrl mask", v, 32'hF700_0000);
    do_wr(2'd2, 32'h0, 4'hF);

    // R1 unused index
    do_wr(2'd3, 32'hFFFF_FFFF, 4'hF);
    check_rd(2'd1, "R1 idx3 poly kept");
    check_rd(2'd2, "R1 idx3 ctrl kept");
    bus_rd(2'd3, v); check_val("R1 idx3 reads zero", v, 32'h0);

    // R6 / R7 partial seeds
    do_wr(2'd2, 32'h0300_0000, 4'h8);
    do_wr(2'd0, 32'h1122_3344, 4'hF);
    do_wr(2'd0, 32'hAABB_CCDD, 4'h6);
    bus_rd(2'd0, v); check_val("R6 partial seed", v, 32'h11BB_CC44);
    do_wr(2'd2, 32'hC300_0000, 4'h8);
    do_wr(2'd0, 32'hAABB_CCDD, 4'h1);
    bus_rd(2'd0, v); check_val("R7 byte swap seed", v, 32'hDDBB_CC44);

    // R5 MSB-first CRC-32 with complement
    do_wr(2'd1, 32'h04C1_1DB7, 4'hF);
    do_wr(2'd2, 32'h0300_0000, 4'h8);
    do_wr(2'd0, 32'hFFFF_FFFF, 4'hF);
    do_wr(2'd2, 32'h0500_0000, 4'h8);
    feed_ascii("123456789");
    bus_rd(2'd0, v); check_val("R5 R9 crc32 msb-first", v, 32'hFC89_1918);

    // R7 R8 R9 reflected CRC-32
    do_wr(2'd2, 32'h4300_0000, 4'h8);
    do_wr(2'd0, 32'hFFFF_FFFF, 4'hF);
    do_wr(2'd2, 32'h6500_0000, 4'h8);
    do_wr(2'd0, 32'h3433_3231, 4'hF);
    do_wr(2'd0, 32'h3837_3635, 4'hF);
    do_wr(2'd0, 32'h0000_0039, 4'h1);
    bus_rd(2'd0, v); check_val("R7 R8 R9 crc32 reflected", v, 32'hCBF4_3926);
    check_val("R8 reflected model", v, m_rd(2'd0));

    // R10 complement and reads leave state alone
    do_wr(2'd2, 32'h0500_0000, 4'h8);
    check_rd(2'd0, "R10 inv read");
    check_rd(2'd0, "R10 inv read again");
    do_wr(2'd2, 32'h0100_0000, 4'h8);
    check_rd(2'd0, "R10 plain after inv");

    // sweep: width x write mode x read mode x complement
    for (int w = 0; w < 2; w++)
      for (int tw = 0; tw < 4; tw++)
        for (int tr = 0; tr < 4; tr++)
          for (int fx = 0; fx < 2; fx++) begin
            logic [31:0] cbase;
            cbase = {tw[1:0], tr[1:0], 1'b0, fx[0], 1'b0, w[0], 24'h0};
            do_wr(2'd1, w ? 32'h04C1_1DB7 : 32'hBEEF_1021, 4'hF);
            do_wr(2'd2, cbase | 32'h0200_0000, 4'h8);
            do_wr(2'd0, 32'h5A5A_C3C3 ^ {tw[7:0], tr[7:0], fx[7:0], w[7:0]}, 4'hF);
            check_rd(2'd0, "R6 R8 sweep seed");
            do_wr(2'd2, cbase, 4'h8);
            do_wr(2'd0, 32'h3132_3334 + cbase, 4'hF);
            do_wr(2'd0, 32'hA1B2_C3D4, 4'h5);
            do_wr(2'd0, 32'h0F1E_2D3C, 4'h8);
            do_wr(2'd0, 32'h00FF_00FF, 4'h6);
            do_wr(2'd0, 32'h1234_5678, 4'h0);
            check_rd(2'd0, "R4 R5 R7 R8 R9 sweep");
          end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule